// File: doc/BRIEF.md
# Multi-Mode Logarithmic Barrel Shifter

This block moves a 32-bit word by any distance from 0 to 31 bit positions in a single combinational pass. A 2-bit mode input picks one of four operations: left shift with zero fill, right shift with zero fill, right shift that copies the sign bit, or rotate right. It is meant to sit inside an execution unit whose decode logic has already turned an immediate or register field into a plain 5-bit amount.

Internally the word passes through one multiplexer row for each power of two below the width. Row k moves the word by 2^k places when bit k of the amount is set, and otherwise passes it through unchanged. Each row is told separately what to feed into the positions it vacates: zero, the sign bit of the original operand, or the bits leaving the low end (rotate). Left shifts reuse the same right-directed rows by reversing the bit order of the word on entry and again on exit.

The block has no states and no transitions. A small control decoder turns the mode into three signals: reverse, wrap and fill. There is no register anywhere in the path.

Top module: `bshift_core`

## Requirements
- R1: Mode 2'b00 gives a left shift: out = in << amount, and the low `amount` result bits are 0.
- R2: Mode 2'b01 gives a right logical shift: out = in >> amount, and the high `amount` result bits are 0.
- R3: Mode 2'b10 gives a right arithmetic shift: the vacated high bits are copies of in[31], and the result MSB always equals in[31].
- R4: Mode 2'b11 gives a rotate right: the bits that leave bit 0 come back in at bit 31, so out = (in >> amount) | (in << (32 - amount)) for amount > 0. The number of set bits is preserved.
- R5: An amount of 0 passes the input through unchanged in every mode.
- R6: The result is combinational. It is valid in the same clock cycle as the inputs, with no clock edge in between.
- R7: At the largest amount (31), a left shift leaves only in[0] at bit 31, a logical right shift leaves only in[31] at bit 0, and an arithmetic right shift fills every bit with in[31].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | 32 | Operand word |
| shamt | input | 5 | Resolved shift distance, 0 to 31 |
| mode | input | 2 | 00 left, 01 right logical, 10 right arithmetic, 11 rotate right |
| data_out | output | 32 | Shifted or rotated result |

## Verification
Every result is due in the same cycle as its inputs, with zero register latency. The bench applies the operands on the falling clock edge and samples `data_out` one nanosecond later, before the next rising edge, so no clock edge lies between stimulus and check. The sweep covers all four modes and all 32 amounts. It uses fixed patterns and random words with the MSB forced high and forced low. Each result is compared with an arithmetic model written in the bench.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

    // The encoding is significant: the bench drives these exact values.
    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_mode_e;

    // Per-row controls produced by the mode decoder.
    typedef struct packed {
        logic reverse;  // mirror the bit order around the right-shift rows
        logic wrap;     // rows feed back the bits that leave the low end
        logic use_sign; // rows fill with the operand MSB instead of 0
    } shift_ctrl_t;

endpackage

// File: rtl/bshift_mirror.sv
module bshift_mirror #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] din,
    input  logic             en,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] flipped;

    // Pure wiring: bit i swaps with bit WIDTH-1-i.
    for (genvar i = 0; i < WIDTH; i++) begin : g_flip
        assign flipped[i] = din[WIDTH-1-i];
    end

    assign dout = en ? flipped : din;
endmodule

// File: rtl/bshift_stage.sv
module bshift_stage #(
    parameter int WIDTH = 32,
    parameter int DIST  = 1
) (
    input  logic [WIDTH-1:0] din,
    input  logic             en,
    input  logic             wrap,
    input  logic             fill,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] moved;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i + DIST < WIDTH) begin : g_inner
            // The source bit is still inside the word.
            assign moved[i] = din[i + DIST];
        end else begin : g_edge
            // Vacated position: take the wrapped bit or the fill value.
            assign moved[i] = wrap ? din[i + DIST - WIDTH] : fill;
        end
    end

    assign dout = en ? moved : din;
endmodule

// File: rtl/bshift_core.sv
module bshift_core
    import bshift_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data_in,
    input  logic [AMT_W-1:0] shamt,
    input  logic [1:0]       mode,
    output logic [WIDTH-1:0] data_out
);
    shift_mode_e mode_e;
    shift_ctrl_t ctrl;
    logic        fill_bit;

    assign mode_e = shift_mode_e'(mode);

    // Mode decode: the only control logic in the block.
    always_comb begin
        ctrl = '0;
        unique case (mode_e)
            SH_LSL: ctrl = '{reverse: 1'b1, wrap: 1'b0, use_sign: 1'b0};
            SH_LSR: ctrl = '{reverse: 1'b0, wrap: 1'b0, use_sign: 1'b0};
            SH_ASR: ctrl = '{reverse: 1'b0, wrap: 1'b0, use_sign: 1'b1};
            SH_ROR: ctrl = '{reverse: 1'b0, wrap: 1'b1, use_sign: 1'b0};
        endcase
    end

    // The fill comes from the original operand, so every row sees the same sign.
    assign fill_bit = ctrl.use_sign & data_in[WIDTH-1];

    logic [WIDTH-1:0] row [AMT_W+1];
    logic [WIDTH-1:0] pre_word;

    bshift_mirror #(.WIDTH(WIDTH)) u_mirror_in (
        .din  (data_in),
        .en   (ctrl.reverse),
        .dout (pre_word)
    );

    assign row[0] = pre_word;

    // One row per power of two; bit k of the amount enables row k.
    for (genvar k = 0; k < AMT_W; k++) begin : g_row
        bshift_stage #(.WIDTH(WIDTH), .DIST(1 << k)) u_stage (
            .din  (row[k]),
            .en   (shamt[k]),
            .wrap (ctrl.wrap),
            .fill (fill_bit),
            .dout (row[k+1])
        );
    end

    bshift_mirror #(.WIDTH(WIDTH)) u_mirror_out (
        .din  (row[AMT_W]),
        .en   (ctrl.reverse),
        .dout (data_out)
    );
endmodule

// File: rtl/bshift_checker.sv
module bshift_checker #(
    parameter int WIDTH = 32,
    parameter int AMT_W = 5
) (
    input logic [WIDTH-1:0] data_in,
    input logic [AMT_W-1:0] shamt,
    input logic [1:0]       mode,
    input logic [WIDTH-1:0] data_out
);
    logic [WIDTH-1:0] all_ones;
    logic [WIDTH-1:0] low_mask;
    logic [WIDTH-1:0] high_mask;

    assign all_ones  = '1;
    assign low_mask  = ~(all_ones << shamt);
    assign high_mask = ~(all_ones >> shamt);

    always_comb begin
        if (!$isunknown({data_in, shamt, mode, data_out})) begin
            AST_ZERO_PASS:   assert (shamt != '0 || data_out == data_in); // R5
            AST_LEFT_LOW:    assert (mode != 2'b00 || (data_out & low_mask) == '0); // R1
            AST_RIGHT_HIGH:  assert (mode != 2'b01 || (data_out & high_mask) == '0); // R2
            AST_SIGN_KEEP:   assert (mode != 2'b10 || data_out[WIDTH-1] == data_in[WIDTH-1]); // R3
            AST_ROT_COUNT:   assert (mode != 2'b11 || $countones(data_out) == $countones(data_in)); // R4
        end
    end
endmodule

bind bshift_core bshift_checker #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_chk (
    .data_in  (data_in),
    .shamt    (shamt),
    .mode     (mode),
    .data_out (data_out)
);

// File: tb/tb_bshift_core.sv
module tb_bshift_core;
    logic        clk = 1'b0;
    logic [31:0] data_in = '0;
    logic [4:0]  shamt = '0;
    logic [1:0]  mode = '0;
    logic [31:0] data_out;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bshift_core dut (
        .data_in  (data_in),
        .shamt    (shamt),
        .mode     (mode),
        .data_out (data_out)
    );

    function automatic logic [31:0] model(input logic [31:0] d, input int s, input int m);
        logic [63:0] dbl;
        case (m)
            0: return d << s;
            1: return d >> s;
            2: return $unsigned($signed(d) >>> s);
            default: begin
                dbl = {d, d} >> s;
                return dbl[31:0];
            end
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s mode=%0d amt=%0d in=%h actual=%h expected=%h",
                     tag, mode, shamt, data_in, got, exp);
        end
    endtask

    // Inputs change on the falling edge; the result is sampled 1 ns later, same cycle (R6).
    task automatic apply(input logic [31:0] d, input int s, input int m);
        string tag;
        @(negedge clk);
        data_in = d;
        shamt   = 5'(s);
        mode    = 2'(m);
        #1;
        if (s == 0) tag = "R5";
        else case (m)
            0: tag = "R1";
            1: tag = "R2";
            2: tag = "R3";
            default: tag = "R4";
        endcase
        check(tag, data_out, model(d, s, m));
    endtask

    initial begin
        #20000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [6];
        pats[0] = 32'h0000_0000;
        pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'h8000_0001;
        pats[3] = 32'h1234_5678;
        pats[4] = 32'hA5A5_C33C;
        pats[5] = 32'h7FFF_FFFE;

        // Reset-like starting point: all inputs 0 gives 0 (R5).
        #1;
        check("R5", data_out, 32'h0);

        // R6: the output follows new inputs with no clock edge in between.
        @(negedge clk);
        data_in = 32'h0000_00F0; shamt = 5'd4; mode = 2'b01;
        #1;
        check("R6", data_out, 32'h0000_000F);

        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 32; s++) begin
                for (int p = 0; p < 6; p++) apply(pats[p], s, m);
                for (int r = 0; r < 6; r++) begin
                    logic [31:0] v;
                    v = $urandom;
                    v[31] = (r % 2 == 0);
                    apply(v, s, m);
                end
            end
        end

        // R7: the largest amount, checked against hand-computed values.
        @(negedge clk);
        data_in = 32'h8000_0001; shamt = 5'd31; mode = 2'b00;
        #1; check("R7", data_out, 32'h8000_0000);
        mode = 2'b01;
        #1; check("R7", data_out, 32'h0000_0001);
        mode = 2'b10;
        #1; check("R7", data_out, 32'hFFFF_FFFF);
        data_in = 32'h7FFF_FFFF;
        #1; check("R7", data_out, 32'h0000_0000);
        mode = 2'b11;
        #1; check("R4", data_out, 32'hFFFF_FFFE);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule